// File: doc/BRIEF.md
# Multi-Source Fair Word Gatherer

The gatherer sits between a set of per-source entropy word FIFOs and a hash-based mixer. Each of its N identical input ports is the read side of one 32-bit FIFO: an "available" flag, the word at the head and a pop strobe. A health flag comes with each source. The block pulls at most one word per clock and keeps a rotating pointer, so the sources are served in turn. It packs the words into 1024-bit message blocks and offers each finished block to the mixer through a valid/ready handshake.

Fairness is organised in rounds. A round takes at most one word from any source. It closes as soon as words from `cfg_m` distinct sources have been collected, and the first `cfg_n` ports are the ones in use. A stuck or failing source is skipped and cannot stall assembly. A single source cannot fill a round on its own when `cfg_m` is two or more. When fewer than `cfg_m` sources can deliver, the round waits instead of closing short. After every `cfg_x` accepted blocks, with 0 treated as 1, a one-cycle pulse tells the mixer to release its digest. The mixer keeps its state between digests.

Top module: `gath_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the first block is complete, `blk_valid` and `digest_req` are low.
- R2: In any cycle, `src_pop` has at most one bit set. A bit is set only for a source whose `src_avail` is 1 and `src_fail` is 0, whose index is below `cfg_n`, and only while `blk_valid` is low.
- R3: When a fixed set of eligible sources always has data, words are taken in a rotation over that set in ascending index order. Each selection continues from the source after the one served last, and wraps to the lowest index.
- R4: A round takes at most one word from each source and closes once words from `cfg_m` distinct sources have been taken. With `cfg_m` of 2 or more and only one source able to deliver, exactly one word is taken from it.
- R5: While fewer than `cfg_m` sources can complete the open round, no further word is taken. Gathering resumes as soon as one more source becomes eligible.
- R6: A block holds 32 words in arrival order. The first word occupies `blk_data[1023:992]` and the last word occupies `blk_data[31:0]`. Each word is passed through unchanged.
- R7: While `blk_valid` is high and `blk_ready` is low, `blk_valid` stays high, `blk_data` stays stable and no word is popped.
- R8: `digest_req` pulses for one cycle, in the cycle after an accepting handshake that completes a group of `cfg_x` accepted blocks. A value of 0 or 1 gives a pulse after every block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_avail | input | N_SRC | Per-source FIFO not empty |
| src_fail | input | N_SRC | Per-source health failure flag |
| src_word | input | 32*N_SRC | Head word of each FIFO, source s at bits [32s+31:32s] |
| src_pop | output | N_SRC | Per-source read strobe |
| cfg_m | input | CNT_W | Distinct sources needed to close a round |
| cfg_n | input | CNT_W | Number of ports in use (lowest indices) |
| cfg_x | input | X_W | Accepted blocks per digest request |
| blk_valid | output | 1 | Message block ready for the mixer |
| blk_ready | input | 1 | Mixer accepts the block |
| blk_data | output | 1024 | Message block, first word in the top bits |
| digest_req | output | 1 | One-cycle digest request pulse |

## Verification
The hardest situation to reach is a round left open because too few sources can deliver. The bench creates it by sweeping every pattern of dead sources over every port count. Dead sources alternate between an empty FIFO and a raised health flag. For each pattern it runs every legal quorum, and then a quorum one larger than the number of live sources, so that the round has to hang with an exact, computable number of pops. A separate run keeps a single source alive with a quorum of two, then revives a second source to show that the waiting round resumes.

// File: rtl/gath_pkg.sv
package gath_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/gath_round.sv
module gath_round #(
  parameter int N_SRC = 4,
  parameter int CNT_W = $clog2(N_SRC + 1),
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] avail,
  input  logic [N_SRC-1:0] fail,
  input  logic [CNT_W-1:0] cfg_m,
  input  logic [CNT_W-1:0] cfg_n,
  input  logic             hold,
  output logic             take,
  output logic [IDX_W-1:0] gidx,
  output logic [N_SRC-1:0] grant
);
  logic [N_SRC-1:0] served_q, served_d, elig, merged;
  logic [IDX_W-1:0] ptr_q, ptr_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = avail[i] & ~fail[i] & ~served_q[i] & (i < int'(cfg_n)) & ~hold;
  end

  always_comb begin
    take = 1'b0;
    gidx = '0;
    for (int k = 0; k < N_SRC; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N_SRC;
      if (!take && elig[j]) begin
        take = 1'b1;
        gidx = IDX_W'(j);
      end
    end
  end

  assign grant  = take ? (N_SRC'(1) << gidx) : '0;
  assign merged = served_q | grant;

  always_comb begin
    served_d = served_q;
    ptr_d    = ptr_q;
    if (take) begin
      ptr_d    = IDX_W'((int'(gidx) + 1) % N_SRC);
      served_d = ($countones(merged) >= int'(cfg_m)) ? '0 : merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served_q <= '0;
      ptr_q    <= '0;
    end else if (take) begin
      served_q <= served_d;
      ptr_q    <= ptr_d;
    end
  end
endmodule

// File: rtl/gath_pack.sv
module gath_pack
  import gath_pkg::*;
#(
  parameter int BLK_WORDS = 32,
  parameter int BLK_W = BLK_WORDS * WORD_W,
  parameter int CW = $clog2(BLK_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  word_t            word,
  input  logic             blk_ready,
  output logic             blk_valid,
  output logic [BLK_W-1:0] blk_data
);
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             vld_q, vld_d;
  logic [BLK_W-1:0] data_d;

  assign data_d = {blk_data[BLK_W-WORD_W-1:0], word};

  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (vld_q && blk_ready) begin
      vld_d = 1'b0;
      cnt_d = '0;
    end else if (take) begin
      if (cnt_q == CW'(BLK_WORDS - 1)) begin
        vld_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_data <= '0;
    else if (take) blk_data <= data_d;
  end

  assign blk_valid = vld_q;
endmodule

// File: rtl/gath_digest.sv
module gath_digest #(
  parameter int X_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic [X_W-1:0] cfg_x,
  output logic           digest_req
);
  logic [X_W-1:0] cnt_q, cnt_d;
  logic           pulse_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (accept) begin
      if ({1'b0, cnt_q} + 1'b1 >= {1'b0, cfg_x}) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      digest_req <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      digest_req <= pulse_d;
    end
  end
endmodule

// File: rtl/gath_top.sv
module gath_top
  import gath_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int BLK_WORDS = 32,
  parameter int X_W = 8,
  parameter int CNT_W = $clog2(N_SRC + 1),
  parameter int BLK_W = BLK_WORDS * WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_avail,
  input  logic [N_SRC-1:0]        src_fail,
  input  logic [N_SRC*WORD_W-1:0] src_word,
  output logic [N_SRC-1:0]        src_pop,
  input  logic [CNT_W-1:0]        cfg_m,
  input  logic [CNT_W-1:0]        cfg_n,
  input  logic [X_W-1:0]          cfg_x,
  output logic                    blk_valid,
  input  logic                    blk_ready,
  output logic [BLK_W-1:0]        blk_data,
  output logic                    digest_req
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             take;
  logic [IDX_W-1:0] gidx;
  word_t            word_sel;

  gath_round #(.N_SRC(N_SRC), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_round (
    .clk(clk), .rst_n(rst_n), .avail(src_avail), .fail(src_fail),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .hold(blk_valid),
    .take(take), .gidx(gidx), .grant(src_pop)
  );

  assign word_sel = src_word[gidx*WORD_W +: WORD_W];

  gath_pack #(.BLK_WORDS(BLK_WORDS), .BLK_W(BLK_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .word(word_sel),
    .blk_ready(blk_ready), .blk_valid(blk_valid), .blk_data(blk_data)
  );

  gath_digest #(.X_W(X_W)) u_digest (
    .clk(clk), .rst_n(rst_n), .accept(blk_valid & blk_ready),
    .cfg_x(cfg_x), .digest_req(digest_req)
  );
endmodule

// File: rtl/gath_chk.sv
module gath_chk #(
  parameter int N_SRC = 4,
  parameter int CNT_W = 3,
  parameter int BLK_W = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_avail,
  input logic [N_SRC-1:0] src_fail,
  input logic [N_SRC-1:0] src_pop,
  input logic [CNT_W-1:0] cfg_n,
  input logic             blk_valid,
  input logic             blk_ready,
  input logic [BLK_W-1:0] blk_data,
  input logic             digest_req
);
  logic [N_SRC-1:0] in_use;
  for (genvar i = 0; i < N_SRC; i++) begin : g_use
    assign in_use[i] = (i < int'(cfg_n));
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!blk_valid && !digest_req));
  // R2
  pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(src_pop));
  // R2
  pop_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pop & ~(src_avail & ~src_fail & in_use)) == '0);
  // R7
  hold_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (src_pop == '0));
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_data)));
  // R8
  digest_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digest_req |-> $past(blk_valid && blk_ready));
endmodule

bind gath_top gath_chk #(.N_SRC(N_SRC), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_avail(src_avail), .src_fail(src_fail),
  .src_pop(src_pop), .cfg_n(cfg_n), .blk_valid(blk_valid),
  .blk_ready(blk_ready), .blk_data(blk_data), .digest_req(digest_req)
);

// File: tb/test_gath_top.sv
module test_gath_top;
  localparam int N = 4;
  localparam int BW = 32;
  localparam int BLKW = BW * 32;

  logic clk, rst_n;
  logic [N-1:0] src_avail, src_fail, src_pop;
  logic [N*32-1:0] src_word;
  logic [2:0] cfg_m, cfg_n;
  logic [7:0] cfg_x;
  logic blk_valid, blk_ready, digest_req;
  logic [BLKW-1:0] blk_data;

  int checks, errors, seq [N], pop_total, cycles;

  gath_top i_gath_top (
    .clk(clk), .rst_n(rst_n), .src_avail(src_avail), .src_fail(src_fail),
    .src_word(src_word), .src_pop(src_pop), .cfg_m(cfg_m), .cfg_n(cfg_n),
    .cfg_x(cfg_x), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_data(blk_data), .digest_req(digest_req)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always_comb
    for (int s = 0; s < N; s++) src_word[s*32 +: 32] = {8'(s), 24'(seq[s])};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N; s++) seq[s] <= 0;
      pop_total <= 0;
    end else begin
      for (int s = 0; s < N; s++) if (src_pop[s]) seq[s] <= seq[s] + 1;
      if (src_pop != 0) pop_total <= pop_total + 1;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R5 actual=%0d expected<=150000 cycles", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input int n, input int m, input int x, input int dead);
    rst_n = 0; blk_ready = 1;
    cfg_n = 3'(n); cfg_m = 3'(m); cfg_x = 8'(x);
    for (int s = 0; s < N; s++) begin
      src_avail[s] = !(dead[s] && (s % 2 == 0));
      src_fail[s]  = dead[s] && (s % 2 == 1);
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic [31:0] exp_word(input int k, input int live[N], input int e);
    return {8'(live[k % e]), 24'(k / e)};
  endfunction

  task automatic check_block(input int b, input int live[N], input int e, input string tag);
    int bad;
    logic [31:0] a, x;
    bad = -1;
    for (int i = 0; i < 32; i++) begin
      x = exp_word(b * 32 + i, live, e);
      if (blk_data[BLKW-1-32*i -: 32] != x && bad < 0) begin
        bad = i; a = blk_data[BLKW-1-32*i -: 32];
      end
    end
    if (bad < 0) check(1, tag, 0, 0);
    else begin
      x = exp_word(b * 32 + bad, live, e);
      check(0, tag, longint'(a), longint'(x));
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int t = 0; t < 300 && !got; t++) begin
      @(negedge clk);
      if (blk_valid) got = 1;
    end
  endtask

  initial begin
    int live [N];
    int e;
    bit got;
    logic [BLKW-1:0] snap;
    int p0, acc, pulses;
    checks = 0; errors = 0; cycles = 0;
    src_avail = 0; src_fail = 0; blk_ready = 1;
    cfg_m = 1; cfg_n = 4; cfg_x = 0;
    rst_n = 0;
    @(negedge clk);
    // R1 quiet reset
    check(!blk_valid && !digest_req, "R1 reset", {blk_valid, digest_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!blk_valid && !digest_req, "R1 after release", {blk_valid, digest_req}, 0);

    // Sweep: port count, dead-source pattern, quorum (R2 R3 R5 R6)
    for (int n = 1; n <= N; n++) begin
      for (int dead = 0; dead < (1 << n); dead++) begin
        e = 0;
        for (int s = 0; s < n; s++) if (!dead[s]) begin live[e] = s; e++; end
        for (int m = 1; m <= e; m++) begin
          restart(n, m, 0, dead);
          for (int b = 0; b < 2; b++) begin
            wait_valid(got);
            check(got, "R3 block arrives", got, 1);
            if (got) check_block(b, live, e, "R2 R3 R6 block content");
          end
        end
        if (e + 1 <= n) begin
          restart(n, e + 1, 0, dead);
          repeat (80) @(negedge clk);
          check(pop_total == e && !blk_valid, "R5 short round waits", pop_total, e);
        end
      end
    end

    // R4: single live source with quorum 2, then a second revives
    restart(4, 2, 0, 4'b1110);
    repeat (40) @(negedge clk);
    check(pop_total == 1 && seq[0] == 1, "R4 one word per source per round", pop_total, 1);
    src_avail[2] = 1;
    repeat (10) @(negedge clk);
    check(pop_total >= 3, "R5 resumes after revival", pop_total, 3);

    // R7: backpressure
    restart(4, 4, 0, 0);
    blk_ready = 0;
    for (int s = 0; s < N; s++) live[s] = s;
    wait_valid(got);
    snap = blk_data; p0 = pop_total;
    got = 1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (!blk_valid || blk_data != snap || pop_total != p0) got = 0;
    end
    check(got, "R7 hold while not ready", pop_total, p0);
    check_block(0, live, 4, "R6 R7 held block content");
    blk_ready = 1;
    @(negedge clk);
    wait_valid(got);
    check(got, "R7 second block after release", got, 1);
    if (got) check_block(1, live, 4, "R7 second block content");

    // R8: digest every 3, then every block with 0
    for (int xi = 0; xi < 2; xi++) begin
      restart(4, 4, (xi == 0) ? 3 : 0, 0);
      acc = 0; pulses = 0;
      for (int t = 0; t < 400 && acc < 6; t++) begin
        @(negedge clk);
        if (digest_req) begin
          pulses++;
          check(acc % ((xi == 0) ? 3 : 1) == 0 && acc > 0, "R8 pulse position", acc, 3);
        end
        if (blk_valid && blk_ready) acc++;
      end
      @(negedge clk);
      if (digest_req) pulses++;
      @(negedge clk);
      if (digest_req) pulses++;
      check(pulses == ((xi == 0) ? 2 : 6), "R8 pulse count", pulses, (xi == 0) ? 2 : 6);
    end

    summary();
  end
endmodule